// File: doc/BRIEF.md
# Serial Memory Write-Protection and Status Logic

This block sits next to the command decoder of a serial nonvolatile memory. It decides whether writes may proceed. It keeps the protection fields of the status register: a two-bit region selector and a pin-enable bit. On every cycle it tells the controller whether an array write to the presented address is allowed. It also builds the status byte that the controller shifts out on a status read.

The front end reports a status-register write request while the device is selected. The request is held pending, and it becomes effective only when the select line is released. The hardware guard pin can block these writes, but only when the pin-enable bit is set. It can also cancel a pending write, up until the moment the write commits. Once the write has committed, the pin no longer affects it. Array writes are checked against the region selector and the write-enable latch. An array write that targets a protected address is refused on the spot.

Top module: `nvm_protect_unit`

## Requirements
- R1: After reset the pin-enable bit and the region selector hold their reset parameters (both 0 by default), so that statusByte shows only the write-enable latch and busy inputs.
- R2: statusByte has this layout: bit 7 is the pin-enable bit, bits 6:4 read as 0, bits 3:2 are the region selector, bit 1 is the wrEnable input and bit 0 is the cycleBusy input.
- R3: The region selector decides which array addresses are protected, based on the top two address bits. Value 00 protects nothing. Value 01 protects addresses whose top bits are 11. Value 10 protects addresses whose top bit is 1. Value 11 protects every address. arrayWrOk is 0 for any protected address.
- R4: arrayWrOk is 1 only while wrEnable is 1. The guard pin has no effect on array writes.
- R5: A status write request made while wrEnable is 0 is ignored. No commit follows, and the fields keep their values.
- R6: A status write request is accepted while selectN is low. When selectN next rises, statCommit is 1 for that one cycle, and the new fields are visible from the following cycle on.
- R7: While the pin-enable bit is 1 and guardPin is 0, a status write request is not accepted and no pending write commits. While the pin-enable bit is 0, guardPin has no effect.
- R8: If the pin-enable bit is 1 and guardPin goes low while a status write is pending, that write is cancelled. It stays cancelled even if guardPin returns high before selectN rises.
- R9: After a status write has committed, a later low level on guardPin leaves the stored fields unchanged.
- R10: A status write stores only data bits 7 and 3:2. A status write request made while selectN is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| selectN | input | 1 | Device select, low while a frame is active |
| guardPin | input | 1 | Hardware write guard; a low level blocks status writes when pin-enable is set |
| wrEnable | input | 1 | Write-enable latch state from the controller |
| cycleBusy | input | 1 | Internal write cycle in progress |
| statWrReq | input | 1 | One-cycle request for a status write |
| statWrData | input | 8 | Status byte supplied with the request |
| reqAddr | input | ADDR_W | Array address of a requested write |
| arrayWrOk | output | 1 | Array write at reqAddr is allowed |
| statCommit | output | 1 | Status write commits in this cycle |
| statusByte | output | 8 | Status byte to be read back |

## Verification
The hardest case to reach is a cancelled status write. The guard pin has to drop and then recover inside a single selected frame, after the request has been accepted but before select is released. The pin-enable bit must already be set at that point. The bench first commits pin-enable with the guard high. It then opens a new frame and pulses the guard low for one cycle between the request and the release. Finally it checks that there was no commit strobe and that the stored byte is unchanged. Putting the same pulse just after a commit shows that a committed write can no longer be reverted.

// File: rtl/nvm_protect_pkg.sv
package nvm_protect_pkg;

  localparam int ST_PIN_EN = 7;
  localparam int ST_RGN_HI = 3;
  localparam int ST_RGN_LO = 2;
  localparam int ST_LATCH  = 1;
  localparam int ST_BUSY   = 0;

  typedef struct packed {
    logic capture;
    logic commit;
    logic drop;
  } statStrobe_t;

  function automatic logic inRegion(input logic [1:0] rgn, input logic [1:0] topBits);
    logic hit;
    case (rgn)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (topBits == 2'b11);
      2'b10:   hit = topBits[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/nvm_protect_ctrl.sv
module nvm_protect_ctrl
  import nvm_protect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selectN,
  input  logic        guardPin,
  input  logic        wrEnable,
  input  logic        statWrReq,
  input  logic        pinEnable,
  output statStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_PEND} ctrlState_t;

  ctrlState_t state;
  logic selPrev;
  logic selRise;
  logic pinBlocks;

  assign pinBlocks = pinEnable && !guardPin;
  assign selRise   = selectN && !selPrev;

  always_comb begin
    strobe.capture = statWrReq && !selectN && wrEnable && !pinBlocks;
    strobe.commit  = (state == ST_PEND) && selRise && !pinBlocks;
    strobe.drop    = (state == ST_PEND) && pinBlocks;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 1'b1;
      state   <= ST_IDLE;
    end else begin
      selPrev <= selectN;
      if (strobe.capture)
        state <= ST_PEND;
      else if (strobe.commit || strobe.drop || selRise)
        state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/nvm_protect_dpath.sv
module nvm_protect_dpath
  import nvm_protect_pkg::*;
#(
  parameter int   ADDR_W   = 14,
  parameter logic RESET_EN = 1'b0,
  parameter logic [1:0] RESET_RGN = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic [7:0]        statWrData,
  input  logic              wrEnable,
  input  logic              cycleBusy,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              pinEnable,
  output logic              arrayWrOk,
  output logic [7:0]        statusByte
);

  localparam int TOP_LO = ADDR_W - 2;

  logic       shadowEn;
  logic [1:0] shadowRgn;
  logic       enQ;
  logic [1:0] rgnQ;
  logic       unusedBits;

  assign unusedBits = ^{statWrData[6:4], statWrData[1:0], reqAddr[TOP_LO-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowEn  <= 1'b0;
      shadowRgn <= 2'b00;
      enQ       <= RESET_EN;
      rgnQ      <= RESET_RGN;
    end else begin
      if (strobe.capture) begin
        shadowEn  <= statWrData[ST_PIN_EN];
        shadowRgn <= statWrData[ST_RGN_HI:ST_RGN_LO];
      end
      if (strobe.commit) begin
        enQ  <= shadowEn;
        rgnQ <= shadowRgn;
      end
    end
  end

  assign pinEnable = enQ;
  assign arrayWrOk = wrEnable && !inRegion(rgnQ, reqAddr[ADDR_W-1:TOP_LO]);

  always_comb begin
    statusByte = 8'h00;
    statusByte[ST_PIN_EN] = enQ;
    statusByte[ST_RGN_HI:ST_RGN_LO] = rgnQ;
    statusByte[ST_LATCH] = wrEnable;
    statusByte[ST_BUSY] = cycleBusy;
  end

endmodule

// File: rtl/nvm_protect_unit.sv
module nvm_protect_unit
  import nvm_protect_pkg::*;
#(
  parameter int   ADDR_W   = 14,
  parameter logic RESET_EN = 1'b0,
  parameter logic [1:0] RESET_RGN = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selectN,
  input  logic              guardPin,
  input  logic              wrEnable,
  input  logic              cycleBusy,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              arrayWrOk,
  output logic              statCommit,
  output logic [7:0]        statusByte
);

  statStrobe_t strobe;
  logic        pinEnable;

  nvm_protect_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .selectN(selectN), .guardPin(guardPin),
    .wrEnable(wrEnable), .statWrReq(statWrReq), .pinEnable(pinEnable),
    .strobe(strobe)
  );

  nvm_protect_dpath #(.ADDR_W(ADDR_W), .RESET_EN(RESET_EN), .RESET_RGN(RESET_RGN)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statWrData(statWrData),
    .wrEnable(wrEnable), .cycleBusy(cycleBusy), .reqAddr(reqAddr),
    .pinEnable(pinEnable), .arrayWrOk(arrayWrOk), .statusByte(statusByte)
  );

  assign statCommit = strobe.commit;

endmodule

// File: rtl/nvm_protect_chk.sv
module nvm_protect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       selectN,
  input logic       guardPin,
  input logic       wrEnable,
  input logic       arrayWrOk,
  input logic       statCommit,
  input logic [7:0] statusByte
);

  p_commit_on_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    statCommit |-> (selectN && !$past(selectN)));

  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !statCommit |=> $stable({statusByte[7], statusByte[3:2]}));

  p_pin_blocks_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    statCommit |-> (guardPin || !statusByte[7]));

  p_full_region_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b11) |-> !arrayWrOk);

  p_latch_gates_array_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrEnable |-> !arrayWrOk);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000);

endmodule

bind nvm_protect_unit nvm_protect_chk i_chk (
  .clk(clk), .rstN(rstN), .selectN(selectN), .guardPin(guardPin),
  .wrEnable(wrEnable), .arrayWrOk(arrayWrOk), .statCommit(statCommit),
  .statusByte(statusByte)
);

// File: tb/test_nvm_protect_unit.sv
module test_nvm_protect_unit;

  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selectN = 1'b1;
  logic guardPin = 1'b1;
  logic wrEnable = 1'b1;
  logic cycleBusy = 1'b1;
  logic statWrReq = 1'b0;
  logic [7:0] statWrData = 8'h00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic arrayWrOk;
  logic statCommit;
  logic [7:0] statusByte;

  int vecCount = 0;
  int missCount = 0;
  logic commitSeen;
  logic [1:0] curRgn;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  nvm_protect_unit #(.ADDR_W(ADDR_W)) i_nvm_protect_unit (
    .clk(clk), .rstN(rstN), .selectN(selectN), .guardPin(guardPin),
    .wrEnable(wrEnable), .cycleBusy(cycleBusy), .statWrReq(statWrReq),
    .statWrData(statWrData), .reqAddr(reqAddr), .arrayWrOk(arrayWrOk),
    .statCommit(statCommit), .statusByte(statusByte)
  );

  // entry: {rgn[1:0], topBits[1:0], wrEnable, expected arrayWrOk}
  localparam logic [5:0] VEC [0:11] = '{
    {2'b00, 2'b00, 1'b1, 1'b1}, {2'b00, 2'b11, 1'b1, 1'b1}, {2'b00, 2'b11, 1'b0, 1'b0},
    {2'b01, 2'b10, 1'b1, 1'b1}, {2'b01, 2'b11, 1'b1, 1'b0}, {2'b01, 2'b00, 1'b0, 1'b0},
    {2'b10, 2'b01, 1'b1, 1'b1}, {2'b10, 2'b10, 1'b1, 1'b0}, {2'b10, 2'b11, 1'b1, 1'b0},
    {2'b11, 2'b00, 1'b1, 1'b0}, {2'b11, 2'b01, 1'b1, 1'b0}, {2'b11, 2'b11, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one selected frame with a status write; optional one-cycle guard pulse before release
  task automatic statWrite(input logic [7:0] data, input bit guardPulse);
    @(negedge clk);
    selectN = 1'b0; statWrReq = 1'b1; statWrData = data;
    @(negedge clk);
    statWrReq = 1'b0;
    if (guardPulse) begin
      guardPin = 1'b0;
      @(negedge clk);
      guardPin = 1'b1;
    end
    @(negedge clk);
    selectN = 1'b1;
    #1 commitSeen = statCommit;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!doneFlag) begin
      missCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", statusByte, 8'h03);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after release", statusByte, 8'h03);
    cycleBusy = 1'b0;
    #1 check("R2 busy bit clear", statusByte, 8'h02);

    // region table walk
    curRgn = 2'b00;
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][5:4] != curRgn) begin
        wrEnable = 1'b1;
        statWrite({4'b0000, VEC[i][5:4], 2'b00}, 0);
        curRgn = VEC[i][5:4];
        check("R3 region programmed", {6'b0, statusByte[3:2]}, {6'b0, curRgn});
      end
      @(negedge clk);
      wrEnable = VEC[i][1];
      reqAddr = {VEC[i][3:2], 12'h5A3};
      #1 check(VEC[i][1] ? "R3 region decode" : "R4 latch gates array", {7'b0, arrayWrOk}, {7'b0, VEC[i][0]});
    end

    // R10: only bits 7 and 3:2 stored (pin-enable ends up 0)
    wrEnable = 1'b1;
    statWrite(8'h73, 0);
    check("R10 masked write commit", {7'b0, commitSeen}, 8'h01);
    check("R10 masked fields", statusByte, 8'h02);

    // R4: guard pin does not affect array writes
    @(negedge clk);
    guardPin = 1'b0; reqAddr = {2'b11, 12'h001};
    #1 check("R4 guard ignored for array", {7'b0, arrayWrOk}, 8'h01);

    // R7: pin-enable 0, guard low, write still commits
    statWrite(8'h88, 0);
    check("R7 pin disabled commit", {7'b0, commitSeen}, 8'h01);
    check("R7 pin disabled fields", statusByte, 8'h8A);
    guardPin = 1'b1;

    // R5: latch low, request ignored
    wrEnable = 1'b0;
    statWrite(8'h00, 0);
    check("R5 no commit without latch", {7'b0, commitSeen}, 8'h00);
    check("R5 fields kept", statusByte, 8'h88);
    wrEnable = 1'b1;

    // R7: pin-enable 1 and guard low blocks the request
    guardPin = 1'b0;
    statWrite(8'h04, 0);
    check("R7 guard blocks commit", {7'b0, commitSeen}, 8'h00);
    check("R7 guard blocks fields", statusByte, 8'h8A);
    guardPin = 1'b1;

    // R8: guard pulse while pending cancels
    statWrite(8'h04, 1);
    check("R8 cancelled commit", {7'b0, commitSeen}, 8'h00);
    check("R8 cancelled fields", statusByte, 8'h8A);

    // R6: commit pulse only in release cycle, fields visible one cycle later
    @(negedge clk);
    selectN = 1'b0; statWrReq = 1'b1; statWrData = 8'h84;
    @(negedge clk);
    statWrReq = 1'b0;
    @(negedge clk);
    selectN = 1'b1;
    #1 check("R6 commit strobe", {7'b0, statCommit}, 8'h01);
    check("R6 fields before edge", statusByte, 8'h8A);
    @(negedge clk);
    check("R6 commit one cycle", {7'b0, statCommit}, 8'h00);
    check("R6 new fields", statusByte, 8'h86);

    // R9: guard low after commit has no effect
    guardPin = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 committed fields kept", statusByte, 8'h86);
    guardPin = 1'b1;

    // R10: request with select high ignored
    @(negedge clk);
    statWrReq = 1'b1; statWrData = 8'h00;
    @(negedge clk);
    statWrReq = 1'b0;
    selectN = 1'b0;
    @(negedge clk);
    selectN = 1'b1;
    #1 check("R10 idle request no commit", {7'b0, statCommit}, 8'h00);
    @(negedge clk);
    check("R10 idle request fields", statusByte, 8'h86);

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule